// File: doc/BRIEF.md
# Reconfigurable Test Register

This block is a register bank placed between two pieces of combinational logic. A two-bit mode input reconfigures it on the fly. In functional use it is an ordinary parallel-load register. For test it can become one of three things. It can be a linear-feedback shift register that drives pseudo-random vectors into the logic it feeds. It can be a multiple-input compactor that folds the responses of the logic feeding it into a signature. It can also be a serial shift chain, which lets a tester write or read the whole state through one pin at each end.

The register shifts toward its most significant stage. In the shifting modes, stage 0 takes either the serial input or the feedback bit. The feedback bit is the XOR of the stages picked by a tap mask parameter. The default mask gives a maximal-length sequence for the default width. In generator mode, an all-zero state is replaced by a seed input, so the generator cannot stick at zero. The serial output is wired to the top stage in every mode.

Top module: `bilbo_reg`

## Requirements
- R1: While `rst` is high at a rising clock edge, the register (and so `dout`) becomes all zero after that edge.
- R2: With mode code 2'b11, `dout` equals the `din` value present at the preceding rising edge.
- R3: With mode code 2'b01, the register is cleared to all zero at the edge, whatever `din`, `seed` and `scan_in` are.
- R4: With mode code 2'b00, the next state is the current state shifted up one stage, with `scan_in` entering stage 0. A word sent most significant bit first therefore appears whole on `dout` after WIDTH shifts.
- R5: With mode code 2'b10 and `compact_sel` low (generator), a nonzero state moves to {state[WIDTH-2:0], fb}. Here fb is the XOR of the state bits where TAPS has a 1 (default 8'hB8: bits 7, 5, 4, 3). `din` has no effect on the result.
- R6: In generator mode, an all-zero state is replaced by `seed` at the next edge.
- R7: In generator mode with the default parameters, any nonzero start state comes back for the first time after exactly 255 steps.
- R8: With mode code 2'b10 and `compact_sel` high (compactor), the next state is {state[WIDTH-2:0], fb} XOR `din`, bit by bit. An all-zero state gets no seed substitution in this mode.
- R9: `scan_out` equals the top stage, `dout[WIDTH-1]`, in every mode.
- R10: `rst` takes priority over every mode code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 shift chain, 01 clear, 10 generator/compactor, 11 functional load |
| compact_sel | input | 1 | In mode 10: 1 selects compactor, 0 selects generator |
| seed | input | WIDTH | State loaded when the generator finds an all-zero state |
| din | input | WIDTH | Parallel data from the upstream logic |
| scan_in | input | 1 | Serial input into stage 0 |
| dout | output | WIDTH | Registered state, driving the downstream logic |
| scan_out | output | 1 | Serial output, top stage |

## Verification
Every result of this block is due exactly one rising edge after the inputs that cause it, because the state register is the only storage between the inputs and `dout`. The bench changes inputs one time unit after an edge. It advances a reference state once per edge, using its own next-state function. It compares `dout` and `scan_out` one time unit after that edge. Multi-step results, such as a full serial word or the generator period, are built from these single-edge steps. They are checked only when their last step has completed.

// File: rtl/bilbo_pkg.sv
package bilbo_pkg;

  typedef enum logic [1:0] {
    MODE_SCAN  = 2'b00,
    MODE_CLEAR = 2'b01,
    MODE_TEST  = 2'b10,
    MODE_FUNC  = 2'b11
  } bilbo_mode_e;

endpackage

// File: rtl/bilbo_feedback.sv
module bilbo_feedback #(
  parameter int              WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS = 8'hB8
) (
  input  logic [WIDTH-1:0] state,
  output logic             fb
);

  logic [WIDTH-1:0] tap_hit;

  for (genvar i = 0; i < WIDTH; i++) begin : g_tap
    if (TAPS[i]) begin : g_used
      assign tap_hit[i] = state[i];
    end else begin : g_unused
      assign tap_hit[i] = 1'b0;
    end
  end

  assign fb = ^tap_hit;

endmodule

// File: rtl/bilbo_next_state.sv
module bilbo_next_state
  import bilbo_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  bilbo_mode_e      mode,
  input  logic             compact_sel,
  input  logic [WIDTH-1:0] state,
  input  logic             fb,
  input  logic [WIDTH-1:0] din,
  input  logic [WIDTH-1:0] seed,
  input  logic             scan_in,
  output logic [WIDTH-1:0] nxt
);

  logic [WIDTH-1:0] shifted_fb;
  logic [WIDTH-1:0] shifted_si;
  logic [WIDTH-1:0] folded;
  logic             is_zero;

  assign shifted_fb = {state[WIDTH-2:0], fb};
  assign shifted_si = {state[WIDTH-2:0], scan_in};
  assign is_zero    = (state == '0);

  for (genvar i = 0; i < WIDTH; i++) begin : g_fold
    assign folded[i] = shifted_fb[i] ^ din[i];
  end

  always_comb begin
    case (mode)
      MODE_SCAN:  nxt = shifted_si;
      MODE_CLEAR: nxt = '0;
      MODE_TEST: begin
        if (compact_sel)  nxt = folded;
        else if (is_zero) nxt = seed;
        else              nxt = shifted_fb;
      end
      default:    nxt = din;
    endcase
  end

endmodule

// File: rtl/bilbo_reg.sv
module bilbo_reg
  import bilbo_pkg::*;
#(
  parameter int              WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS = 8'hB8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             compact_sel,
  input  logic [WIDTH-1:0] seed,
  input  logic [WIDTH-1:0] din,
  input  logic             scan_in,
  output logic [WIDTH-1:0] dout,
  output logic             scan_out
);

  localparam int TOP = WIDTH - 1;

  bilbo_mode_e      mode_e;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;
  logic             fb;

  assign mode_e = bilbo_mode_e'(mode);

  bilbo_feedback #(.WIDTH(WIDTH), .TAPS(TAPS)) u_feedback (
    .state (state_q),
    .fb    (fb)
  );

  bilbo_next_state #(.WIDTH(WIDTH)) u_next (
    .mode        (mode_e),
    .compact_sel (compact_sel),
    .state       (state_q),
    .fb          (fb),
    .din         (din),
    .seed        (seed),
    .scan_in     (scan_in),
    .nxt         (state_d)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= '0;
    else     state_q <= state_d;
  end

  assign dout     = state_q;
  assign scan_out = state_q[TOP];

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (dout == '0)); // R1

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11) |=> (dout == $past(din))); // R2

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) |=> (dout == '0)); // R3

  AST_SCAN_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |=> (dout[0] == $past(scan_in)) &&
                        (dout[TOP:1] == $past(dout[TOP-1:0]))); // R4

  AST_GEN_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && !compact_sel && dout != '0) |=>
      (dout[TOP:1] == $past(dout[TOP-1:0]))); // R5

  AST_GEN_NO_LOCK: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && !compact_sel && dout == '0) |=>
      (dout == $past(seed))); // R6

  AST_COMPACT_FOLD: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && compact_sel) |=>
      (dout[TOP:1] == ($past(dout[TOP-1:0]) ^ $past(din[TOP:1])))); // R8

endmodule

// File: tb/bilbo_reg_bench.sv
module bilbo_reg_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam logic [W-1:0] TAPS = 8'hB8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   mode = 2'b11;
  logic         compact_sel = 1'b0;
  logic [W-1:0] seed = '0;
  logic [W-1:0] din = '0;
  logic         scan_in = 1'b0;
  logic [W-1:0] dout;
  logic         scan_out;

  int total = 0;
  int bad = 0;
  logic [W-1:0] exp_q = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bilbo_reg #(.WIDTH(W), .TAPS(TAPS)) u_bilbo_reg (
    .clk(clk), .rst(rst), .mode(mode), .compact_sel(compact_sel),
    .seed(seed), .din(din), .scan_in(scan_in),
    .dout(dout), .scan_out(scan_out)
  );

  function automatic logic [W-1:0] ref_next(logic [W-1:0] q, logic [1:0] m,
      logic cs, logic [W-1:0] d, logic si, logic [W-1:0] sd);
    logic [W-1:0] sh;
    sh = {q[W-2:0], ^(q & TAPS)};
    case (m)
      2'b00:   return {q[W-2:0], si};
      2'b01:   return '0;
      2'b10:   return cs ? (sh ^ d) : ((q == '0) ? sd : sh);
      default: return d;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic step(logic [1:0] m, logic cs, logic [W-1:0] d, logic si,
                      logic [W-1:0] sd, string req);
    mode = m; compact_sel = cs; din = d; scan_in = si; seed = sd;
    exp_q = ref_next(exp_q, m, cs, d, si, sd);
    @(posedge clk); #1;
    check(req, 32'(dout), 32'(exp_q));
    check("R9", 32'(scan_out), 32'(exp_q[W-1]));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // R10: reset overrides a functional load of all ones
    rst = 1'b1; mode = 2'b11; din = 8'hFF;
    @(posedge clk); @(posedge clk); #1;
    check("R1", 32'(dout), 32'h0);
    check("R10", 32'(dout), 32'h0);
    rst = 1'b0; exp_q = '0;

    step(2'b11, 1'b0, 8'hA5, 1'b0, 8'h00, "R2");
    step(2'b11, 1'b1, 8'h3C, 1'b1, 8'hFF, "R2");
    step(2'b01, 1'b1, 8'hFF, 1'b1, 8'hFF, "R3");

    // R4: shift in 0xD2, most significant bit first
    for (int i = W - 1; i >= 0; i--) step(2'b00, 1'b0, 8'hFF, 1'(8'hD2 >> i), 8'h00, "R4");
    check("R4", 32'(dout), 32'hD2);

    // R6: cleared state escapes to seed; R5: din has no effect
    step(2'b01, 1'b0, 8'h00, 1'b0, 8'h00, "R3");
    step(2'b10, 1'b0, 8'hFF, 1'b0, 8'h5A, "R6");
    check("R6", 32'(dout), 32'h5A);
    for (int i = 0; i < 6; i++) step(2'b10, 1'b0, W'($urandom), 1'b0, 8'h5A, "R5");

    // R7: period of the generator from state 0x01
    for (int i = W - 1; i >= 0; i--) step(2'b00, 1'b0, 8'h00, 1'(8'h01 >> i), 8'h00, "R4");
    begin
      int steps = 0;
      do begin
        step(2'b10, 1'b0, W'($urandom), 1'b0, 8'h77, "R5");
        steps++;
      end while (dout != 8'h01 && steps < 300);
      check("R7", 32'(steps), 32'd255);
    end

    // R8: compactor, including a zero state held by zero input
    step(2'b01, 1'b0, 8'h00, 1'b0, 8'h00, "R3");
    step(2'b10, 1'b1, 8'h00, 1'b0, 8'hAA, "R8");
    check("R8", 32'(dout), 32'h0);
    step(2'b10, 1'b1, 8'h81, 1'b0, 8'hAA, "R8");
    step(2'b10, 1'b1, 8'h7E, 1'b0, 8'hAA, "R8");
    for (int i = 0; i < 8; i++) step(2'b10, 1'b1, W'($urandom), 1'b0, 8'hAA, "R8");

    // mixed random traffic across all modes
    for (int i = 0; i < 1500; i++) begin
      logic [1:0] m = 2'($urandom);
      logic cs = 1'($urandom);
      string tag;
      case (m)
        2'b00:   tag = "R4";
        2'b01:   tag = "R3";
        2'b10:   tag = cs ? "R8" : "R5";
        default: tag = "R2";
      endcase
      step(m, cs, W'($urandom), 1'($urandom), W'($urandom), tag);
    end

    // R10: reset mid-run while in generator mode
    mode = 2'b10; rst = 1'b1;
    @(posedge clk); #1;
    check("R10", 32'(dout), 32'h0);
    rst = 1'b0; exp_q = '0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule